// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands and returns a 32-bit product together with overflow, underflow and invalid flags. A request is made by raising `start_i` for one cycle while the block is idle. The operands are captured, the significands are multiplied and the exponents summed, and the product is then normalized, rounded to nearest with ties to even, and packed. The result and flags stay on the outputs until the next request finishes.

The control is a four-state machine. IDLE waits for `start_i` and captures both operands when it sees it (IDLE to MULT). MULT classifies the operands, settles the special cases, multiplies the 24-bit significands and forms the unbiased exponent sum, and always moves to ROUND (MULT to ROUND). ROUND normalizes the 48-bit product in one step. If the exponent is too small it shifts the product right into the denormal range, rounds with guard, round and sticky bits, renormalizes on a rounding carry, checks for overflow and registers the outputs (ROUND to DONE). DONE raises `done_o` for one cycle and always returns to IDLE (DONE to IDLE).

An operand with a zero exponent field, whether its fraction is zero or not, is taken as a signed zero. An all-ones exponent field marks infinity when the fraction is zero and NaN otherwise.

Top module: `fpmul_seq`

## Requirements
- R1: Every result that is not a NaN carries a sign bit equal to the XOR of the two operand sign bits. This includes zeros and infinities.
- R2: For two finite normal operands, the 24-bit significands (hidden 1 prepended) are multiplied and the biased exponents are summed less 127. A product of 2 or more is shifted right once and the exponent incremented. An in-range result has all three flags low.
- R3: Rounding is to nearest, using the guard bit and the round bit just below the 24-bit significand and a sticky OR of every lower bit. An exact tie rounds to the value whose fraction bit 0 is 0.
- R4: If rounding carries the significand to 2.0, the exponent is incremented and the fraction is zero.
- R5: A final biased exponent of 255 or more, before or after the rounding carry, gives infinity (exponent field 255, fraction 0) with the operand-derived sign and `ovf_o`=1. An exponent of 254 is still a finite result.
- R6: A biased exponent below 1 before rounding sets `unf_o`=1. The significand is shifted right by (1 - exponent) with the lost bits kept as sticky, and then rounded. The result has exponent field 0, or 1 when rounding reaches the smallest normal. It becomes a signed zero when nothing remains. An exponent of exactly 1 is not an underflow.
- R7: A zero operand (exponent field 0, including nonzero fractions) times a finite value gives a signed zero with no flags.
- R8: Infinity times a finite nonzero value or times infinity gives a signed infinity with no flags.
- R9: Zero times infinity gives the quiet NaN 0x7FC00000 with `inv_o`=1.
- R10: Any NaN operand gives the quiet NaN 0x7FC00000 with `inv_o`=0, taking priority over all other cases.
- R11: A `start_i` sampled high in IDLE is accepted at that clock edge. `done_o` is high for exactly one cycle, after the third rising edge counted from and including the accepting edge. `busy_o` is high in every state except IDLE. Result and flags hold their values until the next completion.
- R12: `start_i` while the block is busy is ignored. The running operation completes with the operands captured at acceptance.
- R13: While `rst_n` is low and after it is released, `busy_o`, `done_o`, all three flags and `prod_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request; accepted only in IDLE |
| op_a_i | input | 32 | First operand, binary32 encoding |
| op_b_i | input | 32 | Second operand, binary32 encoding |
| busy_o | output | 1 | High while an operation is in progress (not IDLE) |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| prod_o | output | 32 | Product, binary32 encoding |
| ovf_o | output | 1 | Result overflowed to infinity |
| unf_o | output | 1 | Exponent fell below the normal range before rounding |
| inv_o | output | 1 | Zero times infinity |

## Verification
The hardest cases to reach from the ports are the rounding carry, where the 48-bit product must equal 2 minus exactly half a unit in the last place, and the denormal tie that rounds up to the smallest normal number. The first is reached with significands 0xE12000 and 0x918E00. Their product is (2^25 - 1) times 2^22, an exact tie with an odd low bit. The same pair with the first exponent raised to 254 makes the carry itself push the result into overflow. The denormal tie uses the largest significand at the minimum exponent times one half, so one right shift leaves a guard bit of 1 with nothing below it.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Control states of the sequencer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MULT  = 2'd1,
        ST_ROUND = 2'd2,
        ST_DONE  = 2'd3
    } fpm_state_e;

    // Operand classes after decoding
    typedef enum logic [1:0] {
        K_ZERO = 2'd0,
        K_NORM = 2'd1,
        K_INF  = 2'd2,
        K_NAN  = 2'd3
    } fpm_kind_e;

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output fpm_kind_e         kind_o
);
    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

    // A zero exponent field is read as zero; nonzero fractions are flushed.
    always_comb begin
        if (exp_i == '0)
            kind_o = K_ZERO;
        else if (exp_i == EXP_ONES)
            kind_o = (frac_i == '0) ? K_INF : K_NAN;
        else
            kind_o = K_NORM;
    end
endmodule

// File: rtl/fpm_core.sv
module fpm_core
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]      op_a_i,
    input  logic [EXP_W+FRAC_W:0]      op_b_i,
    output logic                       spec_o,
    output logic                       spec_inv_o,
    output logic [EXP_W+FRAC_W:0]      spec_res_o,
    output logic                       sign_o,
    output logic [2*(FRAC_W+1)-1:0]    prod_o,
    output logic signed [EXP_W+2:0]    exps_o
);
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XW     = EXP_W + 3;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic [W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [EXP_W-1:0]  exp_v  [2];
    logic [FRAC_W-1:0] frac_v [2];
    fpm_kind_e         kind_v [2];

    assign exp_v[0]  = op_a_i[W-2 -: EXP_W];
    assign exp_v[1]  = op_b_i[W-2 -: EXP_W];
    assign frac_v[0] = op_a_i[FRAC_W-1:0];
    assign frac_v[1] = op_b_i[FRAC_W-1:0];

    // One decoder per operand
    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .exp_i  (exp_v[gi]),
            .frac_i (frac_v[gi]),
            .kind_o (kind_v[gi])
        );
    end

    assign sign_o = op_a_i[W-1] ^ op_b_i[W-1];

    // Significand product with hidden ones; lies in [1,4) scaled by 2^(2*FRAC_W)
    assign prod_o = PROD_W'({1'b1, frac_v[0]}) * PROD_W'({1'b1, frac_v[1]});

    // Biased sum with one bias removed, kept signed for the tiny range
    assign exps_o = XW'(exp_v[0]) + XW'(exp_v[1]) - XW'(BIAS);

    // Special-case resolution; NaN first, then zero times infinity
    always_comb begin
        spec_o     = 1'b1;
        spec_inv_o = 1'b0;
        spec_res_o = QNAN;
        if (kind_v[0] == K_NAN || kind_v[1] == K_NAN) begin
            spec_res_o = QNAN;
        end else if ((kind_v[0] == K_INF && kind_v[1] == K_ZERO) ||
                     (kind_v[0] == K_ZERO && kind_v[1] == K_INF)) begin
            spec_res_o = QNAN;
            spec_inv_o = 1'b1;
        end else if (kind_v[0] == K_INF || kind_v[1] == K_INF) begin
            spec_res_o = {sign_o, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (kind_v[0] == K_ZERO || kind_v[1] == K_ZERO) begin
            spec_res_o = {sign_o, {(W-1){1'b0}}};
        end else begin
            spec_o = 1'b0;
        end
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                     sign_i,
    input  logic [2*(FRAC_W+1)-1:0]  prod_i,
    input  logic signed [EXP_W+2:0]  exps_i,
    output logic [EXP_W+FRAC_W:0]    res_o,
    output logic                     ovf_o,
    output logic                     unf_o
);
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int XW      = EXP_W + 3;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int LOW_W   = PROD_W - SIG_W - 2;

    logic              big;
    logic [PROD_W-1:0] nrm;
    logic [XW-1:0]     e1;
    logic              tiny;
    logic [XW-1:0]     sh;
    logic [PROD_W-1:0] shifted;
    logic              lost;
    logic [SIG_W-1:0]  sig;
    logic              g_bit, r_bit, s_bit, up;
    logic [SIG_W:0]    rsum;
    logic [XW-1:0]     ef;

    always_comb begin
        // One-step normalization: leading one moved to the top bit
        big  = prod_i[PROD_W-1];
        nrm  = big ? prod_i : (prod_i << 1);
        e1   = exps_i + XW'(big);
        tiny = e1[XW-1] || (e1 == '0);

        // Denormal alignment; bits shifted out are folded into sticky
        sh      = tiny ? (XW'(1) - e1) : '0;
        shifted = nrm >> sh;
        lost    = ((shifted << sh) != nrm);

        sig   = shifted[PROD_W-1 -: SIG_W];
        g_bit = shifted[PROD_W-SIG_W-1];
        r_bit = shifted[PROD_W-SIG_W-2];
        s_bit = (|shifted[LOW_W-1:0]) | lost;
        up    = g_bit & (r_bit | s_bit | sig[0]);
        rsum  = {1'b0, sig} + (SIG_W+1)'(up);

        ovf_o = 1'b0;
        unf_o = 1'b0;
        ef    = '0;
        if (tiny) begin
            // Hidden position becomes exponent field 1 if rounding reached it
            unf_o = 1'b1;
            res_o = {sign_i, {(EXP_W-1){1'b0}}, rsum[SIG_W-1], rsum[FRAC_W-1:0]};
        end else begin
            // Carry out of rounding renormalizes; fraction is already zero
            ef = e1 + XW'(rsum[SIG_W]);
            if (ef >= XW'(EXP_MAX)) begin
                ovf_o = 1'b1;
                res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else begin
                res_o = {sign_i, ef[EXP_W-1:0], rsum[FRAC_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/fpmul_seq.sv
module fpmul_seq
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [EXP_W+FRAC_W:0]    op_a_i,
    input  logic [EXP_W+FRAC_W:0]    op_b_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [EXP_W+FRAC_W:0]    prod_o,
    output logic                     ovf_o,
    output logic                     unf_o,
    output logic                     inv_o
);
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XW     = EXP_W + 3;
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [W-1:0] QNAN    =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    fpm_state_e state_q, state_d;

    logic [W-1:0]          a_q, b_q;
    logic                  spec_c, spec_inv_c, sign_c;
    logic [W-1:0]          spec_res_c;
    logic [PROD_W-1:0]     prod_c;
    logic signed [XW-1:0]  exps_c;

    logic                  spec_q, spec_inv_q, sign_q;
    logic [W-1:0]          spec_res_q;
    logic [PROD_W-1:0]     prod_q;
    logic signed [XW-1:0]  exps_q;

    logic [W-1:0]          rnd_res;
    logic                  rnd_ovf, rnd_unf;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_MULT;
            ST_MULT:  state_d = ST_ROUND;
            ST_ROUND: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs of the state machine ----------------
    always_comb begin
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_MULT:  ;
            ST_ROUND: ;
            ST_DONE:  done_o = 1'b1;
        endcase
    end

    // ---------------- datapath stages ----------------
    fpm_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
        .op_a_i     (a_q),
        .op_b_i     (b_q),
        .spec_o     (spec_c),
        .spec_inv_o (spec_inv_c),
        .spec_res_o (spec_res_c),
        .sign_o     (sign_c),
        .prod_o     (prod_c),
        .exps_o     (exps_c)
    );

    fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign_i (sign_q),
        .prod_i (prod_q),
        .exps_i (exps_q),
        .res_o  (rnd_res),
        .ovf_o  (rnd_ovf),
        .unf_o  (rnd_unf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q        <= '0;
            b_q        <= '0;
            spec_q     <= 1'b1;
            spec_inv_q <= 1'b0;
            spec_res_q <= '0;
            sign_q     <= 1'b0;
            prod_q     <= '0;
            exps_q     <= '0;
            prod_o     <= '0;
            ovf_o      <= 1'b0;
            unf_o      <= 1'b0;
            inv_o      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                a_q <= op_a_i;
                b_q <= op_b_i;
            end
            if (state_q == ST_MULT) begin
                spec_q     <= spec_c;
                spec_inv_q <= spec_inv_c;
                spec_res_q <= spec_res_c;
                sign_q     <= sign_c;
                prod_q     <= prod_c;
                exps_q     <= exps_c;
            end
            if (state_q == ST_ROUND) begin
                prod_o <= spec_q ? spec_res_q : rnd_res;
                ovf_o  <= !spec_q && rnd_ovf;
                unf_o  <= !spec_q && rnd_unf;
                inv_o  <= spec_q && spec_inv_q;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_done_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |-> ##3 done_o);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ROUND) |=> $stable(prod_o));

    assert_ignore_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(a_q) && $stable(b_q)));

    assert_product_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROUND && !spec_q) |-> (prod_q[PROD_W-1] || prod_q[PROD_W-2]));

    assert_sign_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(prod_o[W-2 -: EXP_W] == {EXP_W{1'b1}} && prod_o[FRAC_W-1:0] != '0))
        |-> (prod_o[W-1] == (a_q[W-1] ^ b_q[W-1])));

    assert_ovf_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (prod_o[W-2:0] == INF_MAG));

    assert_unf_exp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && unf_o) |-> (prod_o[W-2 -: EXP_W] <= EXP_W'(1)));

    assert_inv_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && inv_o) |-> (prod_o == QNAN));

    assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $onehot0({ovf_o, unf_o, inv_o}));
endmodule

// File: tb/tb_fpmul_seq.sv
module tb_fpmul_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        busy, done, ovf, unf, inv;
    logic [31:0] prod;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fpmul_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .op_a_i(op_a), .op_b_i(op_b),
        .busy_o(busy), .done_o(done), .prod_o(prod),
        .ovf_o(ovf), .unf_o(unf), .inv_o(inv)
    );

    task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual flags=%b res=%h expected flags=%b res=%h",
                     tag, act[34:32], act[31:0], exp[34:32], exp[31:0]);
        end
    endtask

    // Issue one operation and wait for completion; returns {ovf,unf,inv,prod}
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          output logic [34:0] got);
        int n;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 timeout: actual done=0 expected done=1");
        end
        got = {ovf, unf, inv, prod};
        @(negedge clk);
    endtask

    task automatic vec(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] fl, input logic [31:0] res);
        logic [34:0] got;
        run_op(a, b, got);
        chk(tag, got, {fl, res});
    endtask

    task automatic t_reset;
        chk("R13 reset outputs", {ovf, unf, inv, prod}, 35'd0);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0) begin
            fails++;
            $display("FAIL R13 reset: actual busy=%b done=%b expected 0 0", busy, done);
        end
    endtask

    task automatic t_normal;
        vec("R2 2*3",        32'h40000000, 32'h40400000, 3'b000, 32'h40C00000);
        vec("R2 1.5*1.5",    32'h3FC00000, 32'h3FC00000, 3'b000, 32'h40100000);
        vec("R2 max sig sq", 32'h3FFFFFFF, 32'h3FFFFFFF, 3'b000, 32'h407FFFFE);
        vec("R1 neg*pos",    32'hBF800000, 32'h40000000, 3'b000, 32'hC0000000);
        vec("R1 neg*neg",    32'hC0400000, 32'hC0000000, 3'b000, 32'h40C00000);
    endtask

    task automatic t_round;
        vec("R3 tie odd up",   32'h3F800001, 32'h3FC00000, 3'b000, 32'h3FC00002);
        vec("R3 tie even keep",32'h3F800003, 32'h3FC00000, 3'b000, 32'h3FC00004);
        vec("R3 above half",   32'h3F800001, 32'h3FC00001, 3'b000, 32'h3FC00003);
    endtask

    task automatic t_carry;
        vec("R4 round carry",  32'h3FE12000, 32'h3F918E00, 3'b000, 32'h40000000);
    endtask

    task automatic t_overflow;
        vec("R5 overflow",       32'h7F000000, 32'h40000000, 3'b100, 32'h7F800000);
        vec("R5 neg overflow",   32'hFF000000, 32'h40000000, 3'b100, 32'hFF800000);
        vec("R5 carry overflow", 32'h7F612000, 32'h3F918E00, 3'b100, 32'h7F800000);
        vec("R5 exp 254 ok",     32'h7F000000, 32'h3F800000, 3'b000, 32'h7F000000);
    endtask

    task automatic t_underflow;
        vec("R6 denormal",      32'h00800000, 32'h3F000000, 3'b010, 32'h00400000);
        vec("R6 to min normal", 32'h00FFFFFF, 32'h3F000000, 3'b010, 32'h00800000);
        vec("R6 flush neg",     32'h80800000, 32'h30800000, 3'b010, 32'h80000000);
        vec("R6 deep flush",    32'h00800000, 32'h00800000, 3'b010, 32'h00000000);
        vec("R6 exp 1 not tiny",32'h00800000, 32'h3F800000, 3'b000, 32'h00800000);
    endtask

    task automatic t_zero;
        vec("R7 zero signed",   32'h00000000, 32'hC0000000, 3'b000, 32'h80000000);
        vec("R7 denormal in",   32'h00000001, 32'h7F000000, 3'b000, 32'h00000000);
    endtask

    task automatic t_inf;
        vec("R8 inf*-2",        32'h7F800000, 32'hC0000000, 3'b000, 32'hFF800000);
        vec("R8 -inf*-inf",     32'hFF800000, 32'hFF800000, 3'b000, 32'h7F800000);
        vec("R9 zero*inf",      32'h00000000, 32'h7F800000, 3'b001, 32'h7FC00000);
        vec("R9 -inf*-zero",    32'hFF800000, 32'h80000000, 3'b001, 32'h7FC00000);
        vec("R9 denorm*inf",    32'h00000001, 32'h7F800000, 3'b001, 32'h7FC00000);
    endtask

    task automatic t_nan;
        vec("R10 nan*1",        32'h7FC00000, 32'h3F800000, 3'b000, 32'h7FC00000);
        vec("R10 snan*zero",    32'h7F800001, 32'h00000000, 3'b000, 32'h7FC00000);
        vec("R10 nan*inf",      32'hFFFFFFFF, 32'h7F800000, 3'b000, 32'h7FC00000);
    endtask

    task automatic t_latency;
        logic [3:0] seen;
        @(negedge clk);
        op_a = 32'h40000000; op_b = 32'h40000000; start = 1'b1;
        @(negedge clk);              // accepting edge passed
        start = 1'b0;
        seen[0] = done;
        @(negedge clk); seen[1] = done;
        @(negedge clk); seen[2] = done;
        @(negedge clk); seen[3] = done;
        chk("R11 done timing", {31'd0, seen}, {31'd0, 4'b0100});
        chk("R11 result 2*2", {ovf, unf, inv, prod}, {3'b000, 32'h40800000});
        checks++;
        if (busy !== 1'b0) begin
            fails++;
            $display("FAIL R11 busy after done: actual %b expected 0", busy);
        end
    endtask

    task automatic t_busy_ignore;
        logic d_at;
        @(negedge clk);
        op_a = 32'h40000000; op_b = 32'h40400000; start = 1'b1;
        @(negedge clk);              // MULT: new request while busy
        op_a = 32'h00000000; op_b = 32'h7F800000;
        @(negedge clk);              // ROUND: still requesting
        start = 1'b0;
        @(negedge clk);              // DONE
        d_at = done;
        chk("R12 ignored start", {ovf, unf, inv, prod}, {3'b000, 32'h40C00000});
        chk("R12 done seen", {34'd0, d_at}, {34'd0, 1'b1});
        @(negedge clk);
        @(negedge clk);
        chk("R11 result held", {ovf, unf, inv, prod}, {3'b000, 32'h40C00000});
        chk("R12 no second op", {34'd0, busy}, 35'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_normal;
        t_round;
        t_carry;
        t_overflow;
        t_underflow;
        t_zero;
        t_inf;
        t_nan;
        t_latency;
        t_busy_ignore;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run;
    end
endmodule